// File: doc/BRIEF.md
# Coprocessor Instruction Word Decoder

This block sits beside a host pipeline and screens each instruction word it is offered. A word belongs to the coprocessor when its upper 22 bits match a fixed base pattern, 0x00201000. For such a word, bits 9:5 hold a 5-bit opcode and bits 4:0 hold a 5-bit register code. Words outside that space are left to the host: the decoder neither dispatches nor traps on them.

Inside the space, one opcode (17) is a unit-control command. Its register code is a sub-command: 0 turns the unit on and 1 turns it off. Only a single enable flag changes; no other state is touched. The opcodes 23 and above always trap. Every other opcode is dispatched while the unit is on and traps while it is off. On a dispatch the block registers the opcode and the 64-bit general-purpose operand. For load and store opcodes it also extracts a row index from the operand.

All results are registered. They appear for one cycle, in the cycle after the input is presented with its valid bit.

Top module: `cop_decoder`

## Requirements
- R1: A word whose bits 31:10 differ from 0x00201000's bits 31:10 produces no dispatch and no trap, and leaves the enable flag unchanged.
- R2: Opcode 17 with register code 0 sets the enable flag, visible on unit_enabled the cycle after, without dispatch or trap.
- R3: Opcode 17 with register code 1 clears the enable flag, visible the cycle after, without dispatch or trap.
- R4: Opcode 17 with any register code from 2 to 31 raises a trap and leaves the enable flag unchanged.
- R5: Opcodes 23 to 31 raise a trap whether the unit is enabled or not, and are never dispatched.
- R6: While enabled, opcodes 0–16 and 18–22 raise dispatch for one cycle. On that cycle out_opcode carries the opcode, out_operand carries the operand, and no trap is raised.
- R7: While disabled, opcodes 0–16 and 18–22 raise a trap instead of a dispatch. On a trap, out_opcode carries the trapping opcode.
- R8: On a dispatch of opcodes 0–3, out_row is operand bits 58:56 zero-extended to 6 bits. For opcodes 4–7 it is operand bits 61:56. out_row_valid is high only on dispatches of opcodes 0–7, and out_row is 0 otherwise.
- R9: dispatch and trap are never high together. Each goes high only in the cycle after a cycle with in_valid high.
- R10: After reset the enable flag is 0 and dispatch, trap and out_row_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word and operand are presented this cycle |
| in_word | input | 32 | Instruction word |
| in_operand | input | 64 | General-purpose operand value |
| unit_enabled | output | 1 | Current enable flag |
| dispatch | output | 1 | One-cycle strobe: legal operation issued |
| trap | output | 1 | One-cycle strobe: illegal-instruction trap |
| out_opcode | output | 5 | Opcode of the dispatched or trapping word |
| out_operand | output | 64 | Operand of the dispatched word |
| out_row | output | 6 | Row index decoded for load/store opcodes |
| out_row_valid | output | 1 | out_row is meaningful this cycle |

## Verification
The enable flag is the only state that outlives one instruction. A wrong value shows on unit_enabled one cycle after the command that set it. It also shows on the next ordinary opcode, which comes out as a trap instead of a dispatch, or the reverse. A wrong match or class decision shows in the very next cycle as a strobe that fires when it should not, or stays low when it should fire. A wrong row extraction shows in that same cycle as a mismatched out_row, which the bench detects by setting all high operand bits around the field.

// File: rtl/cop_pkg.sv
package cop_pkg;
  localparam int WORD_W   = 32;
  localparam int OP_W     = 5;
  localparam int RC_W     = 5;
  localparam int FIELD_W  = OP_W + RC_W;
  localparam int OPND_W   = 64;
  localparam int ROW_W    = 6;
  localparam int XY_ROW_W = 3;
  localparam int ROW_LSB  = 56;

  localparam logic [WORD_W-1:0] SPACE_BASE = 32'h0020_1000;

  localparam logic [OP_W-1:0] OP_XY_LAST    = 5'd3;
  localparam logic [OP_W-1:0] OP_LS_LAST    = 5'd7;
  localparam logic [OP_W-1:0] OP_UNIT_CTL   = 5'd17;
  localparam logic [OP_W-1:0] OP_TRAP_FIRST = 5'd23;

  localparam logic [RC_W-1:0] RC_ON  = 5'd0;
  localparam logic [RC_W-1:0] RC_OFF = 5'd1;

  typedef enum logic [2:0] {
    K_NONE,
    K_ISSUE,
    K_TRAP,
    K_ON,
    K_OFF
  } kind_e;

  // Upper bits must equal the base; the low FIELD_W bits carry opcode and register code.
  function automatic logic in_space(input logic [WORD_W-1:0] w);
    return w[WORD_W-1:FIELD_W] == SPACE_BASE[WORD_W-1:FIELD_W];
  endfunction

  function automatic kind_e classify(input logic hit, input logic [OP_W-1:0] op,
                                     input logic [RC_W-1:0] rc, input logic en);
    kind_e k;
    if (!hit)                     k = K_NONE;
    else if (op >= OP_TRAP_FIRST) k = K_TRAP;
    else if (op == OP_UNIT_CTL) begin
      if (rc == RC_ON)            k = K_ON;
      else if (rc == RC_OFF)      k = K_OFF;
      else                        k = K_TRAP;
    end
    else if (!en)                 k = K_TRAP;
    else                          k = K_ISSUE;
    return k;
  endfunction

  function automatic logic is_ls(input logic [OP_W-1:0] op);
    return op <= OP_LS_LAST;
  endfunction

  function automatic logic [ROW_W-1:0] row_pick(input logic [OP_W-1:0] op,
                                                input logic [OPND_W-1:0] opnd);
    logic [ROW_W-1:0] raw;
    logic [ROW_W-1:0] r;
    raw = opnd[ROW_LSB +: ROW_W];
    if (op <= OP_XY_LAST) r = {{(ROW_W-XY_ROW_W){1'b0}}, raw[XY_ROW_W-1:0]};
    else if (is_ls(op))   r = raw;
    else                  r = '0;
    return r;
  endfunction
endpackage

// File: rtl/cop_classify.sv
module cop_classify
  import cop_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic              en,
  output logic              hit,
  output logic [OP_W-1:0]   op,
  output logic [RC_W-1:0]   rc,
  output kind_e             kind
);
  assign op   = word[FIELD_W-1:RC_W];
  assign rc   = word[RC_W-1:0];
  assign hit  = in_space(word);
  assign kind = classify(hit, op, rc, en);
endmodule

// File: rtl/cop_enable_ctl.sv
module cop_enable_ctl
  import cop_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  fire,
  input  kind_e kind,
  output logic  en
);
  always_ff @(posedge clk) begin
    if (!rst_n)                      en <= 1'b0;
    else if (fire && kind == K_ON)   en <= 1'b1;
    else if (fire && kind == K_OFF)  en <= 1'b0;
  end
endmodule

// File: rtl/cop_out_stage.sv
module cop_out_stage
  import cop_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  kind_e             kind,
  input  logic [OP_W-1:0]   op,
  input  logic [OPND_W-1:0] opnd,
  output logic              dispatch,
  output logic              trap,
  output logic [OP_W-1:0]   opcode_q,
  output logic [OPND_W-1:0] opnd_q,
  output logic [ROW_W-1:0]  row_q,
  output logic              row_valid
);
  logic issue, bad;
  assign issue = fire && kind == K_ISSUE;
  assign bad   = fire && kind == K_TRAP;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dispatch  <= 1'b0;
      trap      <= 1'b0;
      opcode_q  <= '0;
      opnd_q    <= '0;
      row_q     <= '0;
      row_valid <= 1'b0;
    end else begin
      dispatch  <= issue;
      trap      <= bad;
      row_valid <= issue && is_ls(op);
      row_q     <= issue ? row_pick(op, opnd) : '0;
      if (issue || bad) opcode_q <= op;
      if (issue)        opnd_q   <= opnd;
    end
  end
endmodule

// File: rtl/cop_decoder.sv
module cop_decoder
  import cop_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  input  logic [OPND_W-1:0] in_operand,
  output logic              unit_enabled,
  output logic              dispatch,
  output logic              trap,
  output logic [OP_W-1:0]   out_opcode,
  output logic [OPND_W-1:0] out_operand,
  output logic [ROW_W-1:0]  out_row,
  output logic              out_row_valid
);
  logic            hit_w;
  logic [OP_W-1:0] op_w;
  logic [RC_W-1:0] rc_w;
  kind_e           kind_w;

  cop_classify u_cls (
    .word (in_word),
    .en   (unit_enabled),
    .hit  (hit_w),
    .op   (op_w),
    .rc   (rc_w),
    .kind (kind_w)
  );

  cop_enable_ctl u_en (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (in_valid),
    .kind  (kind_w),
    .en    (unit_enabled)
  );

  cop_out_stage u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (in_valid),
    .kind      (kind_w),
    .op        (op_w),
    .opnd      (in_operand),
    .dispatch  (dispatch),
    .trap      (trap),
    .opcode_q  (out_opcode),
    .opnd_q    (out_operand),
    .row_q     (out_row),
    .row_valid (out_row_valid)
  );
endmodule

// File: rtl/cop_decoder_chk.sv
module cop_decoder_chk
  import cop_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             hit,
  input logic [OP_W-1:0]  op,
  input logic [RC_W-1:0]  rc,
  input logic             enabled,
  input logic             dispatch,
  input logic             trap,
  input logic [OP_W-1:0]  opcode,
  input logic [ROW_W-1:0] row,
  input logic             row_valid
);
  AST_NO_SPACE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !hit |=> !dispatch && !trap && enabled == $past(enabled)); // R1
  AST_UNIT_ON: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && hit && op == OP_UNIT_CTL && rc == RC_ON |=> enabled && !dispatch && !trap); // R2
  AST_UNIT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && hit && op == OP_UNIT_CTL && rc == RC_OFF |=> !enabled && !dispatch && !trap); // R3
  AST_BAD_SUBCMD: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && hit && op == OP_UNIT_CTL && rc > RC_OFF |=> trap && enabled == $past(enabled)); // R4
  AST_TOP_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && hit && op >= OP_TRAP_FIRST |=> trap && !dispatch); // R5
  AST_ISSUE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && hit && enabled && op < OP_TRAP_FIRST && op != OP_UNIT_CTL
      |=> dispatch && opcode == $past(op)); // R6
  AST_OFF_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && hit && !enabled && op != OP_UNIT_CTL |=> trap && !dispatch); // R7
  AST_ROW_ONLY_LS: assert property (@(posedge clk) disable iff (!rst_n)
    row_valid |-> dispatch && opcode <= OP_LS_LAST); // R8
  AST_ROW_XY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    row_valid && opcode <= OP_XY_LAST |-> row < 6'd8); // R8
  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(dispatch && trap)); // R9
  AST_STROBE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !dispatch && !trap); // R9
endmodule

bind cop_decoder cop_decoder_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .hit       (hit_w),
  .op        (op_w),
  .rc        (rc_w),
  .enabled   (unit_enabled),
  .dispatch  (dispatch),
  .trap      (trap),
  .opcode    (out_opcode),
  .row       (out_row),
  .row_valid (out_row_valid)
);

// File: tb/tb_cop_decoder.sv
module tb_cop_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_word = '0;
  logic [63:0] in_operand = '0;
  logic        unit_enabled, dispatch, trap, out_row_valid;
  logic [4:0]  out_opcode;
  logic [63:0] out_operand;
  logic [5:0]  out_row;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  bit model_en = 0;

  always #4 clk = ~clk;

  cop_decoder dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .in_operand(in_operand), .unit_enabled(unit_enabled), .dispatch(dispatch),
    .trap(trap), .out_opcode(out_opcode), .out_operand(out_operand),
    .out_row(out_row), .out_row_valid(out_row_valid)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int op, input int rc);
    return 32'h0020_1000 + (op << 5) + rc;
  endfunction

  // 0 none, 1 dispatch, 2 trap, 3 on, 4 off
  function automatic int expect_kind(input logic [31:0] w, input bit en);
    int op, rc;
    if ((w & 32'hFFFF_FC00) != 32'h0020_1000) return 0;
    op = int'(w[9:5]);
    rc = int'(w[4:0]);
    if (op > 22) return 2;
    if (op == 17) return (rc == 0) ? 3 : (rc == 1) ? 4 : 2;
    return en ? 1 : 2;
  endfunction

  function automatic logic [5:0] expect_row(input int op, input logic [63:0] v);
    if (op < 4) return {3'b000, v[58:56]};
    if (op < 8) return v[61:56];
    return 6'd0;
  endfunction

  task automatic issue(input logic [31:0] w, input logic [63:0] v, input string req);
    int k, op;
    k  = expect_kind(w, model_en);
    op = int'(w[9:5]);
    in_valid = 1'b1; in_word = w; in_operand = v;
    @(negedge clk);
    in_valid = 1'b0;
    if (k == 3) model_en = 1;
    if (k == 4) model_en = 0;
    check({req, " dispatch"}, {63'd0, dispatch}, {63'd0, k == 1});
    check({req, " trap"}, {63'd0, trap}, {63'd0, k == 2});
    check({req, " enabled"}, {63'd0, unit_enabled}, {63'd0, model_en});
    if (k == 1 || k == 2) check({req, " opcode"}, {59'd0, out_opcode}, 64'(op));
    if (k == 1) begin
      check({req, " operand"}, out_operand, v);
      check({req, " R8 row_valid"}, {63'd0, out_row_valid}, {63'd0, op < 8});
      check({req, " R8 row"}, {58'd0, out_row}, {58'd0, expect_row(op, v)});
    end else begin
      check({req, " R8 row_valid idle"}, {63'd0, out_row_valid}, 64'd0);
    end
  endtask

  task automatic idle_check;
    @(negedge clk);
    check("R9 no strobe when idle", {62'd0, dispatch, trap}, 64'd0);
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    check("R10 reset enabled", {63'd0, unit_enabled}, 64'd0);
    check("R10 reset strobes", {61'd0, dispatch, trap, out_row_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    issue(mk(10, 0), 64'h1, "R7 off fma traps");
    issue(mk(31, 0), 64'h0, "R5 op31 disabled");
    issue(mk(17, 0), 64'h0, "R2 enable");
    issue(32'h0020_1400, 64'h0, "R1 bit10 outside");
    issue(32'hDEAD_BEEF, 64'h0, "R1 foreign word");
    issue(mk(0, 3), 64'hFF00_0000_0000_1234, "R8 X row all-ones");
    issue(mk(3, 0), 64'h0500_0000_0000_0000, "R8 Y row 5");
    issue(mk(4, 0), 64'hFF00_0000_0000_0040, "R8 Z row 63");
    issue(mk(7, 9), 64'h2A00_0000_0000_0000, "R8 Z row 42");
    issue(mk(16, 2), 64'hCAFE_F00D_1234_5678, "R6 fms16");
    issue(mk(22, 0), 64'h77, "R6 op22 dispatched");
    issue(mk(18, 1), 64'h5, "R6 op18 dispatched");
    issue(mk(23, 0), 64'h0, "R5 op23 enabled");
    issue(mk(17, 2), 64'h0, "R4 subcmd 2");
    issue(mk(17, 31), 64'h0, "R4 subcmd 31");
    idle_check();
    issue(mk(17, 1), 64'h0, "R3 disable");
    issue(mk(2, 0), 64'h0100_0000_0000_0000, "R7 store traps");
    issue(mk(17, 1), 64'h0, "R3 disable twice");

    for (int i = 0; i < 600; i++) begin
      logic [31:0] w;
      logic [63:0] v;
      int sel;
      sel = int'($urandom_range(0, 7));
      v = {$urandom, $urandom};
      if (sel < 4)      w = mk(int'($urandom_range(0, 31)), int'($urandom_range(0, 31)));
      else if (sel < 6) w = mk(17, int'($urandom_range(0, 2)));
      else if (sel < 7) w = $urandom;
      else              w = mk(int'($urandom_range(0, 7)), 0);
      issue(w, v, "R6 random");
      if ((i % 50) == 0) idle_check();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule